// File: doc/BRIEF.md
# DRAM Refresh Controller

This block keeps a 128-row dynamic memory array alive. It issues refresh cycles that address one row at a time from an internal 7-bit row counter. It also decides, cycle by cycle, whether the array serves a refresh or a normal processor read/write. Each row must be refreshed at least once in every refresh period of 2 ms. The period length in clock cycles is derived from a clock-frequency parameter.

Two schedules can be chosen at run time. In burst mode all 128 rows are refreshed back to back at the start of a period, and the rest of the period is free for accesses. In periodic mode one row is refreshed per slot, and the slots are spaced evenly across the period. The mode input is sampled only when a period begins, so each period always completes exactly 128 refreshes.

During a refresh the address multiplexer selects the row counter, and only the row strobe is pulsed. An access that is already running is never cut short. A request that meets pending refresh work is held off with a wait signal.

Top module: `dramRefreshTop`

## Requirements
- R1: While `rstN` is low, `addrSelRef`, `rowStrobe`, `accWait` and `accDone` are 0 and `refRow` is 0. After reset is released, the period timer starts at 0. A refresh is scheduled on the first clock edge, so `addrSelRef` is 1 after the second edge, with `refRow` = 0.
- R2: A refresh lasts REF_LEN cycles (3 by default). `addrSelRef` is 1 in every one of those cycles. `rowStrobe` is 0 in the first cycle and 1 in the remaining REF_LEN-1 cycles. `refRow` does not change while `rowStrobe` is 1.
- R3: After each refresh, `refRow` advances by exactly one. After row 127 it wraps to 0, so the row is back at 0 at the end of every complete period.
- R4: In burst mode (`burstMode` = 1 sampled at a period start), 128 refreshes run with no gap. The first and last strobe rises are 127*REF_LEN cycles apart.
- R5: In periodic mode (`burstMode` = 0 sampled at a period start), one refresh is scheduled every floor(PERIOD/128) cycles (15 by default), starting at timer 0. Consecutive refreshes are therefore at least 10 cycles apart.
- R6: `burstMode` is sampled only when the period timer is 0. A change in mid-period does not alter the schedule until the next period.
- R7: An access granted on `accReq` runs ACC_LEN cycles (4 by default) without interruption. `accDone` is 1 in its last cycle. A refresh that comes due during the access starts only after the access ends.
- R8: When refresh work is pending, it is served before a waiting request. `accWait` = `accReq` while no access is running, and it stays 1 until the pending refreshes finish.
- R9: Every period of PERIOD cycles (2000 by default) contains exactly 128 refreshes, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstMode | input | 1 | 1 = burst schedule, 0 = periodic schedule; sampled at period start |
| accReq | input | 1 | Processor access request, held until `accDone` |
| refRow | output | ROW_BITS | Row address for the refresh |
| addrSelRef | output | 1 | Address multiplexer selects the refresh row counter |
| rowStrobe | output | 1 | Row strobe of a refresh cycle |
| accWait | output | 1 | Request is being held off |
| accDone | output | 1 | Last cycle of a granted access |

## Verification
A refresh coming due and a processor request can land in the same cycle. The bench provokes this in periodic mode by raising `accReq` exactly one cycle before a slot tick, and again exactly one cycle after it. In the first case the access must win and the refresh must start right after `accDone`. In the second case `addrSelRef` and `accWait` must both be 1 at once. A behavioural reference model compares every output on every clock, while pseudo-random requests collide with both burst and periodic refreshes.

// File: rtl/refreshPkg.sv
package refreshPkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REFRESH = 2'd1,
    ST_ACCESS  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic rowDone;   // a refresh cycle finishes this clock
  } ctlStrobes_t;
endpackage

// File: rtl/refreshPath.sv
module refreshPath
  import refreshPkg::*;
#(
  parameter int ROW_BITS   = 7,
  parameter int PERIOD_CYC = 2000,
  parameter int SLOT_CYC   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstMode,
  input  ctlStrobes_t         ctl,
  output logic                pendAny,
  output logic                pendMany,
  output logic [ROW_BITS-1:0] refRow
);
  localparam int ROWS    = 1 << ROW_BITS;
  localparam int TIMER_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int SLOT_W  = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int PEND_W  = ROW_BITS + 2;
  localparam logic [TIMER_W-1:0]  TIMER_LAST = TIMER_W'(PERIOD_CYC - 1);
  localparam logic [SLOT_W-1:0]   SLOT_LAST  = SLOT_W'(SLOT_CYC - 1);
  localparam logic [ROW_BITS:0]   SLOT_NUM   = (ROW_BITS + 1)'(ROWS);

  logic [TIMER_W-1:0]  timer;
  logic [SLOT_W-1:0]   slotCnt;
  logic [ROW_BITS:0]   slotNum;
  logic                modeLatched;
  logic [PEND_W-1:0]   pendCnt;
  logic [ROW_BITS-1:0] rowCnt;

  logic              periodStart;
  logic              effBurst;
  logic              slotTick;
  logic [PEND_W-1:0] addRows;

  always_comb begin
    periodStart = (timer == '0);
    effBurst    = periodStart ? burstMode : modeLatched;
    slotTick    = (slotCnt == '0) && (slotNum < SLOT_NUM);
    if (periodStart && effBurst)   addRows = PEND_W'(ROWS);
    else if (!effBurst && slotTick) addRows = PEND_W'(1);
    else                            addRows = '0;
  end

  // period timer and slot bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer       <= '0;
      slotCnt     <= '0;
      slotNum     <= '0;
      modeLatched <= 1'b0;
    end else begin
      timer <= (timer == TIMER_LAST) ? '0 : timer + 1'b1;
      if (timer == TIMER_LAST) begin
        slotCnt <= '0;
        slotNum <= '0;
      end else if (slotCnt == SLOT_LAST) begin
        slotCnt <= '0;
        slotNum <= slotNum + 1'b1;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
      if (periodStart) modeLatched <= burstMode;
    end
  end

  // outstanding refresh work and row counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
      rowCnt  <= '0;
    end else begin
      pendCnt <= pendCnt + addRows - PEND_W'(ctl.rowDone);
      if (ctl.rowDone) rowCnt <= rowCnt + 1'b1;
    end
  end

  assign pendAny  = (pendCnt != '0);
  assign pendMany = (pendCnt > PEND_W'(1));
  assign refRow   = rowCnt;

  // R6: the latched schedule changes only at a period start
  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |=> $stable(modeLatched));

  // R9: outstanding work never exceeds two periods' worth
  a_r9_pend_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(2 * ROWS));

  // R3: the row counter moves only when the control finishes a refresh
  a_r3_row_only_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rowDone |=> $stable(rowCnt));
endmodule

// File: rtl/refreshCtl.sv
module refreshCtl
  import refreshPkg::*;
#(
  parameter int REF_LEN = 3,
  parameter int ACC_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pendAny,
  input  logic        pendMany,
  input  logic        accReq,
  output ctlStrobes_t ctl,
  output logic        addrSelRef,
  output logic        rowStrobe,
  output logic        accWait,
  output logic        accDone
);
  localparam int MAX_LEN = (REF_LEN > ACC_LEN) ? REF_LEN : ACC_LEN;
  localparam int PH_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [PH_W-1:0] REF_LAST = PH_W'(REF_LEN - 1);
  localparam logic [PH_W-1:0] ACC_LAST = PH_W'(ACC_LEN - 1);

  ctlState_t       state, stateNext;
  logic [PH_W-1:0] phase, phaseNext;
  logic            refLast, accLast;

  assign refLast = (state == ST_REFRESH) && (phase == REF_LAST);
  assign accLast = (state == ST_ACCESS) && (phase == ACC_LAST);

  always_comb begin
    stateNext = state;
    phaseNext = phase + 1'b1;
    unique case (state)
      ST_IDLE: begin
        phaseNext = '0;
        if (pendAny)     stateNext = ST_REFRESH;
        else if (accReq) stateNext = ST_ACCESS;
      end
      ST_REFRESH: begin
        if (refLast) begin
          phaseNext = '0;
          stateNext = pendMany ? ST_REFRESH : ST_IDLE;
        end
      end
      ST_ACCESS: begin
        if (accLast) begin
          phaseNext = '0;
          stateNext = ST_IDLE;
        end
      end
      default: begin
        phaseNext = '0;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  assign ctl.rowDone = refLast;
  assign addrSelRef  = (state == ST_REFRESH);
  assign rowStrobe   = (state == ST_REFRESH) && (phase != '0);
  assign accWait     = accReq && (state != ST_ACCESS);
  assign accDone     = accLast;

  // R7: a running access is never interrupted
  a_r7_access_whole: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && !accLast) |=> (state == ST_ACCESS));

  // R8: pending refresh work beats a waiting request
  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pendAny) |=> (state == ST_REFRESH));

  // R4: further pending rows follow with no idle cycle
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (refLast && pendMany) |=> (state == ST_REFRESH && phase == '0));
endmodule

// File: rtl/dramRefreshTop.sv
module dramRefreshTop
  import refreshPkg::*;
#(
  parameter int ROW_BITS   = 7,
  parameter int CLK_MHZ    = 1,
  parameter int REFRESH_US = 2000,
  parameter int REF_LEN    = 3,
  parameter int ACC_LEN    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstMode,
  input  logic                accReq,
  output logic [ROW_BITS-1:0] refRow,
  output logic                addrSelRef,
  output logic                rowStrobe,
  output logic                accWait,
  output logic                accDone
);
  localparam int ROWS       = 1 << ROW_BITS;
  localparam int PERIOD_CYC = CLK_MHZ * REFRESH_US;
  localparam int SLOT_CYC   = PERIOD_CYC / ROWS;

  ctlStrobes_t ctl;
  logic        pendAny, pendMany;

  refreshPath #(
    .ROW_BITS(ROW_BITS), .PERIOD_CYC(PERIOD_CYC), .SLOT_CYC(SLOT_CYC)
  ) i_path (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .ctl(ctl),
    .pendAny(pendAny), .pendMany(pendMany), .refRow(refRow)
  );

  refreshCtl #(
    .REF_LEN(REF_LEN), .ACC_LEN(ACC_LEN)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .pendAny(pendAny), .pendMany(pendMany),
    .accReq(accReq), .ctl(ctl), .addrSelRef(addrSelRef),
    .rowStrobe(rowStrobe), .accWait(accWait), .accDone(accDone)
  );

  // R2: the row address holds while the strobe is active
  a_r2_row_steady: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |-> $stable(refRow));

  // R7: an access never completes while the refresh row is selected
  a_r7_done_apart: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> !addrSelRef);
endmodule

// File: tb/test_dramRefreshTop.sv
module test_dramRefreshTop;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS   = 7;
  localparam int ROWS       = 128;
  localparam int PERIOD     = 2000;
  localparam int REF_LEN    = 3;
  localparam int ACC_LEN    = 4;
  localparam int RUN_CYC    = 6000;

  logic clk = 1'b0;
  logic rstN, burstMode, accReq;
  logic [ROW_BITS-1:0] refRow;
  logic addrSelRef, rowStrobe, accWait, accDone;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dramRefreshTop #(
    .ROW_BITS(ROW_BITS), .CLK_MHZ(1), .REFRESH_US(PERIOD),
    .REF_LEN(REF_LEN), .ACC_LEN(ACC_LEN)
  ) i_dramRefreshTop (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .accReq(accReq),
    .refRow(refRow), .addrSelRef(addrSelRef), .rowStrobe(rowStrobe),
    .accWait(accWait), .accDone(accDone)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model: 0 idle, 1 refresh, 2 access
  int mTimer, mSlotCnt, mSlotNum, mMode, mPend, mRow, mState, mPhase;

  always @(posedge clk) begin
    if (!rstN) begin
      mTimer = 0; mSlotCnt = 0; mSlotNum = 0; mMode = 0;
      mPend = 0; mRow = 0; mState = 0; mPhase = 0;
    end else begin
      automatic bit pStart = (mTimer == 0);
      automatic int eff = pStart ? int'(burstMode) : mMode;
      automatic bit tick = (mSlotCnt == 0) && (mSlotNum < ROWS);
      automatic int add = (pStart && eff == 1) ? ROWS : ((eff == 0 && tick) ? 1 : 0);
      automatic bit fin = (mState == 1) && (mPhase == REF_LEN - 1);
      automatic int nState = mState;
      automatic int nPhase = mPhase + 1;
      cyc++;
      if (mState == 0) begin
        nPhase = 0;
        if (mPend > 0) nState = 1;
        else if (accReq) nState = 2;
      end else if (mState == 1) begin
        if (fin) begin nPhase = 0; nState = (mPend > 1) ? 1 : 0; end
      end else begin
        if (mPhase == ACC_LEN - 1) begin nPhase = 0; nState = 0; end
      end
      mPend = mPend + add - (fin ? 1 : 0);
      if (fin) mRow = (mRow + 1) % ROWS;
      if (pStart) mMode = int'(burstMode);
      if (mTimer == PERIOD - 1) begin mSlotCnt = 0; mSlotNum = 0; end
      else if (mSlotCnt == PERIOD / ROWS - 1) begin mSlotCnt = 0; mSlotNum++; end
      else mSlotCnt++;
      mTimer = (mTimer + 1) % PERIOD;
      mState = nState; mPhase = nPhase;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, RUN_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int riseCnt[3], firstRise[3], lastRise[3], minGap[3];
  int lateRises = 0;
  int lfsr = 16'hACE1;

  initial begin
    bit prevStb;
    int prevRow;
    int stbRun;
    rstN = 1'b0; burstMode = 1'b1; accReq = 1'b0;
    for (int p = 0; p < 3; p++) begin
      riseCnt[p] = 0; firstRise[p] = 0; lastRise[p] = 0; minGap[p] = 1000000;
    end
    repeat (3) begin
      @(negedge clk);
      chk(addrSelRef == 0 && rowStrobe == 0 && accWait == 0 && accDone == 0,
          "R1 reset outputs idle", {addrSelRef, rowStrobe, accWait, accDone}, 0);
      chk(refRow == 0, "R1 reset row", int'(refRow), 0);
    end
    rstN = 1'b1;
    prevStb = 1'b0; prevRow = 0; stbRun = 0;
    for (int n = 1; n <= RUN_CYC; n++) begin
      @(negedge clk);
      // cycle-by-cycle comparison against the model
      chk(addrSelRef == (mState == 1), "R2 mux select", int'(addrSelRef), int'(mState == 1));
      chk(rowStrobe == (mState == 1 && mPhase != 0), "R2 row strobe",
          int'(rowStrobe), int'(mState == 1 && mPhase != 0));
      chk(int'(refRow) == mRow, "R3 row address", int'(refRow), mRow);
      chk(accWait == (accReq && mState != 2), "R8 wait", int'(accWait),
          int'(accReq && mState != 2));
      chk(accDone == (mState == 2 && mPhase == ACC_LEN - 1), "R7 access done",
          int'(accDone), int'(mState == 2 && mPhase == ACC_LEN - 1));
      // port-level observations
      if (cyc == 1) chk(addrSelRef == 0, "R1 first edge", int'(addrSelRef), 0);
      if (cyc == 2) chk(addrSelRef == 1 && refRow == 0 && rowStrobe == 0,
                        "R1 first refresh row0", int'(addrSelRef), 1);
      if (int'(refRow) != prevRow)
        chk(int'(refRow) == (prevRow + 1) % ROWS, "R3 step and wrap", int'(refRow),
            (prevRow + 1) % ROWS);
      if (rowStrobe) stbRun++;
      if (prevStb && !rowStrobe) begin
        chk(stbRun == REF_LEN - 1, "R2 strobe length", stbRun, REF_LEN - 1);
        stbRun = 0;
      end
      if (rowStrobe && !prevStb) begin
        automatic int p = (cyc - 1) / PERIOD;
        if (riseCnt[p] == 0) firstRise[p] = cyc;
        else if (cyc - lastRise[p] < minGap[p]) minGap[p] = cyc - lastRise[p];
        lastRise[p] = cyc;
        riseCnt[p]++;
        if (p == 1 && cyc > 2510) lateRises++;
      end
      if (cyc == 2000) chk(refRow == 0, "R3 wrap at period end", int'(refRow), 0);
      if (cyc == 2151) chk(accWait == 0 && addrSelRef == 0, "R7 access wins tie",
                           int'(accWait) + int'(addrSelRef), 0);
      if (cyc == 2156) chk(addrSelRef == 1, "R7 refresh after access", int'(addrSelRef), 1);
      if (cyc == 2302) chk(accWait == 1 && addrSelRef == 1, "R8 refresh first",
                           int'(accWait) + int'(addrSelRef), 2);
      if (cyc == 2306) chk(accWait == 0, "R8 granted after refresh", int'(accWait), 0);
      prevStb = rowStrobe;
      prevRow = int'(refRow);
      // drive inputs for the next edge
      if (cyc == 1000) burstMode = 1'b0;
      if (cyc == 2500) burstMode = 1'b1;
      if (cyc == 5000) burstMode = 1'b0;
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
      if (accDone) accReq = 1'b0;
      else if (cyc == 2150 || cyc == 2301) accReq = 1'b1;
      else if (!accReq && (lfsr & 15) == 0 &&
               !((cyc % PERIOD) >= 120 && (cyc % PERIOD) <= 170) &&
               !((cyc % PERIOD) >= 280 && (cyc % PERIOD) <= 320))
        accReq = 1'b1;
    end
    for (int p = 0; p < 3; p++)
      chk(riseCnt[p] == ROWS, "R9 refreshes per period", riseCnt[p], ROWS);
    chk(lastRise[0] - firstRise[0] == (ROWS - 1) * REF_LEN, "R4 burst contiguous p0",
        lastRise[0] - firstRise[0], (ROWS - 1) * REF_LEN);
    chk(lastRise[2] - firstRise[2] == (ROWS - 1) * REF_LEN, "R4 burst contiguous p2",
        lastRise[2] - firstRise[2], (ROWS - 1) * REF_LEN);
    chk(minGap[1] >= 10, "R5 periodic spacing", minGap[1], 10);
    chk(lateRises == 94, "R6 mid-period switch ignored", lateRises, 94);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule